// File: doc/BRIEF.md
# Burst Preamble Sequencing Controller

This controller runs the opening of every upstream burst. It watches a pending-data flag and a stream of dequeued code words, and it moves through three phases. In the first phase it sends a clock-recovery preamble and asks for the laser. In the second it sends a framing delimiter. In the third it passes the code words on to the downstream data path. The code words are counted in groups of four. In the two preamble phases, each complete group is replaced by one 66-bit word for the serializer.

The first phase begins emitting when the pending flag rises. Each group of four then produces an alternating sync word. After a set number of groups (`SYNC_GROUPS`), the controller enters the framing phase. There, the next group of four produces the delimiter word (`DELIM_WORD`). On the same edge, the controller enters the data phase and sends a one-cycle reset to the data-path functions: rate adaptation, block encoder, scrambler and FEC encoder. When the pending flag drops during the data phase, the controller returns to the first phase.

Top module: `burst_preamble_seq`

## Requirements
- R1: After reset, `phase` is 0 (preamble). `word_valid`, `dp_reset`, `data_valid` and `path_data` are all 0. `laser_req` follows `data_pending`.
- R2: `laser_req` equals `data_pending` while `phase` is 0. It is 1 while `phase` is 1 (delimiter) or 2 (data).
- R3: In phase 0 with `data_pending` high, every fourth cycle in which `code_valid` is high causes the following effect one cycle later. `word_valid` is high for that one cycle, and `word_out` holds the sync word. The sync word has the value 1 in every odd bit (65, 63, … 1) and 0 in every even bit. Cycles with `code_valid` low do not count.
- R4: The phase encoding is 0 for preamble, 1 for delimiter and 2 for data. The cycle that presents the `SYNC_GROUPS`-th sync word since `data_pending` rose also shows `phase` at 1. The value 3 never appears.
- R5: In phase 0, while `data_pending` is low, no word is emitted, and both the group count and the sync-time count restart. After the flag rises again, a full `SYNC_GROUPS` groups are needed before phase 1.
- R6: In phase 1, the fourth valid code produces `word_out` = `DELIM_WORD` with `word_valid` high, and `phase` changes to 2 in that same cycle. `data_pending` has no effect during phase 1.
- R7: `dp_reset` is high for exactly one cycle, which is the first cycle with `phase` at 2.
- R8: In phase 2, `path_data` is 1, `data_valid` follows `code_valid` combinationally, and `data_out` equals `code_in`. In phases 0 and 1, `data_valid` and `path_data` are 0.
- R9: In phase 2, a cycle with `data_pending` low gives `phase` = 0 one cycle later. No sync word is emitted in phase 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | A code word is dequeued this cycle |
| code_in | input | CODE_W | Dequeued code word |
| data_pending | input | 1 | Non-idle data waits upstream |
| laser_req | output | 1 | Laser-on request |
| word_out | output | 66 | Preamble word (sync or delimiter) |
| word_valid | output | 1 | `word_out` is new this cycle |
| path_data | output | 1 | Codes are routed to the data path |
| data_out | output | CODE_W | Code word toward the data path |
| data_valid | output | 1 | `data_out` carries a code word |
| dp_reset | output | 1 | One-cycle reset to the data-path functions |
| phase | output | 2 | Current phase (0, 1, 2) |

## Verification
The assertions assume that `data_pending` has a defined value in every cycle after reset. The stimulus meets this by always driving the flag from the bench. The exit check for phase 2 depends only on that flag. The assertions also assume that sync and delimiter words are told apart by the phase in which they appear. For this reason the directed sequences use a delimiter value that differs from the sync pattern, and they drive all inputs on the falling edge, so each code is counted on exactly one rising edge.

// File: rtl/burst_preamble_seq.sv
module burst_preamble_seq #(
  parameter int          CODE_W      = 8,
  parameter int          SYNC_GROUPS = 4,
  parameter logic [65:0] DELIM_WORD  = 66'h2_B3E1F0C49A57D21E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_in,
  input  logic              data_pending,
  output logic              laser_req,
  output logic [65:0]       word_out,
  output logic              word_valid,
  output logic              path_data,
  output logic [CODE_W-1:0] data_out,
  output logic              data_valid,
  output logic              dp_reset,
  output logic [1:0]        phase
);
  localparam int          TW       = $clog2(SYNC_GROUPS) + 1;
  localparam logic [1:0]  PH_SYNC  = 2'd0;
  localparam logic [1:0]  PH_DELIM = 2'd1;
  localparam logic [1:0]  PH_DATA  = 2'd2;
  localparam logic [65:0] SYNC_WORD = {33{2'b10}};
  localparam logic [TW-1:0] LAST_GRP = TW'(SYNC_GROUPS - 1);

  logic [1:0]    grp;
  logic [TW-1:0] timer;

  assign laser_req  = (phase != PH_SYNC) || data_pending;
  assign path_data  = (phase == PH_DATA);
  assign data_valid = path_data && code_valid;
  assign data_out   = code_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_SYNC;
      grp        <= 2'd0;
      timer      <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
      dp_reset   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      dp_reset   <= 1'b0;
      case (phase)
        PH_SYNC: begin
          if (!data_pending) begin
            grp   <= 2'd0;
            timer <= '0;
          end else if (code_valid) begin
            grp <= grp + 2'd1;
            if (grp == 2'd3) begin
              word_out   <= SYNC_WORD;
              word_valid <= 1'b1;
              if (timer == LAST_GRP) begin
                phase <= PH_DELIM;
                timer <= '0;
              end else begin
                timer <= timer + TW'(1);
              end
            end
          end
        end
        PH_DELIM: begin
          if (code_valid) begin
            grp <= grp + 2'd1;
            if (grp == 2'd3) begin
              word_out   <= DELIM_WORD;
              word_valid <= 1'b1;
              dp_reset   <= 1'b1;
              phase      <= PH_DATA;
            end
          end
        end
        PH_DATA: begin
          if (!data_pending) begin
            phase <= PH_SYNC;
            grp   <= 2'd0;
            timer <= '0;
          end
        end
        default: phase <= PH_SYNC;
      endcase
    end
  end
endmodule

// File: rtl/burst_preamble_seq_chk.sv
module burst_preamble_seq_chk #(
  parameter logic [65:0] DELIM_WORD = '0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        data_pending,
  input logic        laser_req,
  input logic [65:0] word_out,
  input logic        word_valid,
  input logic        path_data,
  input logic        data_valid,
  input logic        dp_reset,
  input logic [1:0]  phase
);
  localparam logic [65:0] SYNC_PAT = {33{2'b10}};

  AST_LASER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd0) |-> laser_req); // R2
  AST_SYNC_CONTENT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && phase != 2'd2) |-> (word_out == SYNC_PAT)); // R3
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R4
  AST_DELIM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && phase == 2'd2) |-> (word_out == DELIM_WORD && dp_reset)); // R6
  AST_DPRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset |=> !dp_reset); // R7
  AST_DPRST_AT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset |-> (phase == 2'd2 && $past(phase) == 2'd1)); // R7
  AST_NO_DATA_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd2) |-> (!data_valid && !path_data)); // R8
  AST_DATA_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && !data_pending) |=> (phase == 2'd0)); // R9
endmodule

bind burst_preamble_seq burst_preamble_seq_chk #(.DELIM_WORD(DELIM_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_pending(data_pending), .laser_req(laser_req),
  .word_out(word_out), .word_valid(word_valid), .path_data(path_data),
  .data_valid(data_valid), .dp_reset(dp_reset), .phase(phase));

// File: tb/sim_burst_preamble_seq.sv
`timescale 1ns/1ps
module sim_burst_preamble_seq;
  localparam int          CW    = 8;
  localparam int          SG    = 3;
  localparam logic [65:0] DELIM = 66'h1_7C4A93E05B2D86F1;
  localparam logic [65:0] SYNC  = {33{2'b10}};

  logic clk = 1'b0, rst_n = 1'b0, code_valid = 1'b0, data_pending = 1'b0;
  logic [CW-1:0] code_in = '0;
  logic laser_req, word_valid, path_data, data_valid, dp_reset;
  logic [65:0] word_out;
  logic [CW-1:0] data_out;
  logic [1:0] phase;
  logic c_laser, c_dv, c_pd;
  logic [CW-1:0] c_do;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  burst_preamble_seq #(.CODE_W(CW), .SYNC_GROUPS(SG), .DELIM_WORD(DELIM)) u0 (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_in(code_in),
    .data_pending(data_pending), .laser_req(laser_req), .word_out(word_out),
    .word_valid(word_valid), .path_data(path_data), .data_out(data_out),
    .data_valid(data_valid), .dp_reset(dp_reset), .phase(phase));

  task automatic chk(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [CW-1:0] c, input logic p);
    code_valid = v; code_in = c; data_pending = p;
    #1;
    c_laser = laser_req; c_dv = data_valid; c_pd = path_data; c_do = data_out;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; code_valid = 1'b0; data_pending = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_preamble(input string tag);
    for (int i = 0; i < SG * 4; i++) begin
      step(1'b1, CW'(i), 1'b1);
      chk(c_laser == 1'b1, "R2", c_laser, 1);
      chk(c_dv == 1'b0 && c_pd == 1'b0, "R8", c_dv, 0);
      chk(word_valid == (i % 4 == 3), tag, word_valid, (i % 4 == 3));
      if (i % 4 == 3) chk(word_out == SYNC, "R3", word_out, SYNC);
      chk(phase == ((i == SG * 4 - 1) ? 2'd1 : 2'd0), "R4", phase, (i == SG * 4 - 1));
    end
  endtask

  task automatic run_delim(input logic p);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 8'hA0, p);
      chk(c_laser == 1'b1, "R2", c_laser, 1);
      chk(word_valid == (i == 3), "R6", word_valid, (i == 3));
      chk(phase == ((i == 3) ? 2'd2 : 2'd1), "R6", phase, (i == 3) ? 2 : 1);
      chk(dp_reset == (i == 3), "R7", dp_reset, (i == 3));
    end
    chk(word_out == DELIM, "R6", word_out, DELIM);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(phase == 2'd0, "R1", phase, 0);
    chk(!word_valid && !dp_reset && !data_valid && !path_data, "R1", word_valid, 0);
    chk(laser_req == 1'b0, "R1", laser_req, 0);
    @(negedge clk);
  endtask

  task automatic t_burst();
    do_reset();
    step(1'b1, 8'h11, 1'b0);
    chk(c_laser == 1'b0, "R2", c_laser, 0);
    chk(word_valid == 1'b0, "R5", word_valid, 0);
    run_preamble("R3");
    run_delim(1'b1);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, CW'(8'h5A + i), 1'b1);
      chk(c_dv == 1'b1 && c_pd == 1'b1, "R8", c_dv, 1);
      chk(c_do == CW'(8'h5A + i), "R8", c_do, 8'h5A + i);
      chk(dp_reset == 1'b0, "R7", dp_reset, 0);
      chk(word_valid == 1'b0 && phase == 2'd2, "R9", phase, 2);
    end
    step(1'b0, 8'h00, 1'b1);
    chk(c_dv == 1'b0, "R8", c_dv, 0);
    step(1'b1, 8'h77, 1'b0);
    chk(c_dv == 1'b1, "R8", c_dv, 1);
    chk(phase == 2'd0, "R9", phase, 0);
    step(1'b0, 8'h00, 1'b0);
    chk(c_laser == 1'b0, "R2", c_laser, 0);
  endtask

  task automatic t_gap();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(i[0] == 1'b0, 8'h33, 1'b1);
      chk(word_valid == (i == 6), "R3", word_valid, (i == 6));
    end
  endtask

  task automatic t_abort();
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b1, 8'h21, 1'b1);
    step(1'b1, 8'h21, 1'b0);
    chk(word_valid == 1'b0 && phase == 2'd0, "R5", word_valid, 0);
    run_preamble("R5");
  endtask

  task automatic t_frame_ignore();
    do_reset();
    run_preamble("R3");
    run_delim(1'b0);
    step(1'b1, 8'h44, 1'b0);
    chk(c_dv == 1'b1, "R8", c_dv, 1);
    chk(phase == 2'd0 && word_valid == 1'b0, "R9", phase, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_burst();
        t_gap();
        t_abort();
        t_frame_ignore();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule